// File: doc/BRIEF.md
# Multidrop RS-485 Address-Filtering Receiver

This block is the receive half of a UART used on a shared RS-485 bus where many stations listen to one master. Each frame carries a start bit, eight data bits sent least significant bit first, an optional ninth bit, and a stop bit. The ninth bit sits where a parity bit would normally go. On a multidrop link it tells address bytes apart from data bytes. The receiver samples the line on an oversampling tick supplied from outside the block. It turns each frame into a byte with a one-cycle valid pulse and attaches a framing-error flag to that byte.

Three control inputs set how received bytes are handled:

- **Multidrop enable** turns on the nine-bit frame and address recognition.
- **Receiver off** discards data bytes while address bytes are still reported.
- **Auto-filter enable** lets the block decide by itself which data to accept. It compares every address byte with a programmed station address. A match opens the receiver and a mismatch closes it. In this mode address bytes are consumed by the filter and are not passed on.

Top module: `mdrop_rx`

## Requirements
- R1: With `mdrop_en`=0, a frame is start (low), 8 data bits LSB first, stop (high); each byte is delivered on `rx_data` with `rx_is_addr`=0 and `addr_irq` never pulses.
- R2: A low pulse on `rxd` that has ended before the middle of a start bit produces no byte and no interrupt.
- R3: A stop bit sampled low still delivers the byte, with `rx_frame_err`=1 in the same cycle as `rx_valid`; a high stop bit gives `rx_frame_err`=0.
- R4: With `mdrop_en`=1 and `auto_en`=0, the frame has a ninth bit after data bit 7; a value of 1 marks an address. Address bytes are delivered with `rx_is_addr`=1 and a one-cycle `addr_irq` pulse, whether or not `rx_off` is set.
- R5: With `auto_en`=0 and `rx_off`=1, data bytes (ninth bit 0, or any byte when multidrop is off) are discarded. With `rx_off`=0 they are delivered.
- R6: With `mdrop_en`=1 and `auto_en`=1, an address byte equal to `station_addr` pulses `addr_irq`, is not delivered, and opens the receiver so that following data bytes are delivered.
- R7: With `mdrop_en`=1 and `auto_en`=1, an address byte not equal to `station_addr` gives no interrupt, is not delivered, and closes the receiver so that following data bytes are discarded.
- R8: After a synchronous active-low reset, `rx_valid`, `addr_irq`, `rx_is_addr`, `rx_frame_err` and `rx_data` are 0 and the receiver is open.
- R9: `rx_valid` and `addr_irq` are single-cycle pulses, at most one per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| os_tick | input | 1 | Oversample strobe, OVS per bit time |
| mdrop_en | input | 1 | Enable nine-bit multidrop frames |
| rx_off | input | 1 | Discard data bytes (when auto filter off) |
| auto_en | input | 1 | Enable automatic address filtering |
| station_addr | input | 8 | Address this station answers to |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_is_addr | output | 1 | Delivered byte is an address |
| rx_frame_err | output | 1 | Delivered byte had a low stop bit |
| addr_irq | output | 1 | One-cycle address-detected pulse |

## Verification
The hardest state to reach from the ports is the auto-filter gate. It exists only as a consequence of the previous address byte, so it can only be observed through whether the next data byte appears. The bench sweeps all 256 address values against a fixed station address, and follows each address with a data byte. This makes every match and every mismatch both set and clear the gate. It also sends a matching address directly after a mismatching one, so the gate is seen to reopen.

// File: rtl/mdrop_rx_pkg.sv
// Shared types for the multidrop receiver.
// Assumes eight data bits per character.
package mdrop_rx_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ninth;
        logic              ferr;
    } rx_frame_t;
endpackage

// File: rtl/mdrop_rx_deser.sv
// Frame deserializer. It synchronises rxd and hunts for a start bit,
// which it confirms at mid-bit. It then samples data bits, the
// optional ninth bit and the stop bit once per OVS ticks.
// Assumes: os_tick is a one-cycle strobe at OVS times the baud rate,
// and use9 is stable while a frame is in flight.
module mdrop_rx_deser
    import mdrop_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rxd,
    input  logic      os_tick,
    input  logic      use9,
    output logic      frm_valid,
    output rx_frame_t frm
);
    localparam int CNT_W = $clog2(OVS);
    localparam int HALF  = OVS / 2;
    localparam int SH_W  = DATA_W + 1;
    localparam int IDX_W = $clog2(SH_W + 1);

    logic [1:0]       sync_q;
    logic             rxd_s;
    rx_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [SH_W-1:0]  shreg;
    logic             nine_q;
    logic [IDX_W-1:0] last_idx;

    assign rxd_s    = sync_q[1];
    assign last_idx = nine_q ? IDX_W'(SH_W - 1) : IDX_W'(DATA_W - 1);

    // Two-flop synchroniser for the asynchronous serial line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // Frame state machine, advanced on oversample ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            nine_q    <= 1'b0;
            frm_valid <= 1'b0;
            frm       <= '0;
        end else begin
            frm_valid <= 1'b0;
            if (os_tick) begin
                unique case (state)
                    ST_IDLE: begin
                        cnt <= '0;
                        if (!rxd_s) begin
                            state  <= ST_START;
                            nine_q <= use9;
                        end
                    end
                    ST_START: begin
                        if (cnt == CNT_W'(HALF - 1)) begin
                            cnt   <= '0;
                            idx   <= '0;
                            state <= rxd_s ? ST_IDLE : ST_BITS;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_BITS: begin
                        if (cnt == CNT_W'(OVS - 1)) begin
                            cnt   <= '0;
                            shreg <= {rxd_s, shreg[SH_W-1:1]};
                            idx   <= idx + 1'b1;
                            if (idx == last_idx) state <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == CNT_W'(OVS - 1)) begin
                            cnt       <= '0;
                            state     <= ST_IDLE;
                            frm_valid <= 1'b1;
                            frm.ferr  <= !rxd_s;
                            if (nine_q) begin
                                frm.data  <= shreg[DATA_W-1:0];
                                frm.ninth <= shreg[DATA_W];
                            end else begin
                                frm.data  <= shreg[SH_W-1:1];
                                frm.ninth <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R9: a frame takes many cycles, so completion strobes never touch.
    a_r9_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid);
    // R1: an eight-bit frame never reports a ninth bit.
    a_r1_no_ninth_in_8bit: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !nine_q) |-> !frm.ninth);
endmodule

// File: rtl/mdrop_rx_filter.sv
// Address recognition and acceptance filter. It classifies each frame
// as address or data, keeps the receiver-open gate, and registers the
// byte stream and interrupt presented at the block boundary.
// Assumes one frame strobe at most every few cycles.
module mdrop_rx_filter
    import mdrop_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  rx_frame_t         frm,
    input  logic              mdrop_en,
    input  logic              rx_off,
    input  logic              auto_en,
    input  logic [DATA_W-1:0] station_addr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_is_addr,
    output logic              rx_frame_err,
    output logic              addr_irq
);
    logic muted;
    logic is_addr;
    logic auto_mode;
    logic hit;
    logic deliver;
    logic raise;

    assign is_addr   = mdrop_en && frm.ninth;
    assign auto_mode = mdrop_en && auto_en;
    assign hit       = (frm.data == station_addr);
    assign deliver   = frm_valid && (is_addr ? !auto_mode : !muted);
    assign raise     = frm_valid && is_addr && (!auto_mode || hit);

    // Receiver gate: follows rx_off, or is driven by addresses in auto mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                          muted <= 1'b0;
        else if (!auto_mode)                 muted <= rx_off;
        else if (frm_valid && is_addr)       muted <= !hit;
    end

    // Registered output stream and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data      <= '0;
            rx_valid     <= 1'b0;
            rx_is_addr   <= 1'b0;
            rx_frame_err <= 1'b0;
            addr_irq     <= 1'b0;
        end else begin
            rx_valid <= deliver;
            addr_irq <= raise;
            if (deliver) begin
                rx_data      <= frm.data;
                rx_is_addr   <= is_addr;
                rx_frame_err <= frm.ferr;
            end
        end
    end

    // R9: output strobes are single-cycle.
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        addr_irq |=> !addr_irq);
    // R6, R7: in auto mode, address bytes are never passed on.
    a_r6_no_addr_in_auto: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_is_addr) |-> !$past(auto_mode));
    // R4: an interrupt only follows a frame from the deserializer.
    a_r4_irq_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        addr_irq |-> $past(frm_valid && mdrop_en));
    // R1: without multidrop, nothing is tagged as an address.
    a_r1_no_addr_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(mdrop_en)) |-> !rx_is_addr);
endmodule

// File: rtl/mdrop_rx.sv
// Top level of the multidrop receiver: a deserializer feeding an
// address filter. Assumes the baud/oversample strobe comes from outside.
module mdrop_rx
    import mdrop_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              os_tick,
    input  logic              mdrop_en,
    input  logic              rx_off,
    input  logic              auto_en,
    input  logic [DATA_W-1:0] station_addr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_is_addr,
    output logic              rx_frame_err,
    output logic              addr_irq
);
    logic      frm_valid;
    rx_frame_t frm;

    mdrop_rx_deser #(.OVS(OVS)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .os_tick   (os_tick),
        .use9      (mdrop_en),
        .frm_valid (frm_valid),
        .frm       (frm)
    );

    mdrop_rx_filter u_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .frm_valid    (frm_valid),
        .frm          (frm),
        .mdrop_en     (mdrop_en),
        .rx_off       (rx_off),
        .auto_en      (auto_en),
        .station_addr (station_addr),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_is_addr   (rx_is_addr),
        .rx_frame_err (rx_frame_err),
        .addr_irq     (addr_irq)
    );
endmodule

// File: tb/mdrop_rx_bench.sv
// Self-checking bench. Oversample tick every clock with OVS=8, so one
// bit lasts 8 clocks. A monitor counts output strobes at negedge.
module mdrop_rx_bench;
    localparam int OVS = 8;
    localparam int BIT = OVS;
    localparam logic [7:0] STATION = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       mdrop_en = 1'b0;
    logic       rx_off = 1'b0;
    logic       auto_en = 1'b0;
    logic [7:0] station_addr = STATION;
    logic [7:0] rx_data;
    logic       rx_valid, rx_is_addr, rx_frame_err, addr_irq;

    int n_checks = 0;
    int n_errors = 0;
    int n_rx = 0;
    int n_irq = 0;
    logic [7:0] last_data = '0;
    logic       last_addr = 1'b0;
    logic       last_ferr = 1'b0;

    always #2 clk = ~clk;

    mdrop_rx #(.OVS(OVS)) u_mdrop_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(1'b1),
        .mdrop_en(mdrop_en), .rx_off(rx_off), .auto_en(auto_en),
        .station_addr(station_addr), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_is_addr(rx_is_addr), .rx_frame_err(rx_frame_err), .addr_irq(addr_irq)
    );

    // Monitor: record every delivered byte and interrupt.
    always @(negedge clk) begin
        if (rx_valid) begin
            n_rx++;
            last_data = rx_data;
            last_addr = rx_is_addr;
            last_ferr = rx_frame_err;
        end
        if (addr_irq) n_irq++;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic nine, input logic use9, input logic stop);
        @(negedge clk) rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (use9) begin
            rxd = nine;
            repeat (BIT) @(negedge clk);
        end
        rxd = stop;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : stim
        int rx0, irq0;
        repeat (4) @(negedge clk);
        // R8: reset state
        check("R8", "rx_valid", rx_valid, 0);
        check("R8", "addr_irq", addr_irq, 0);
        check("R8", "rx_data", rx_data, 0);
        check("R8", "rx_is_addr", rx_is_addr, 0);
        check("R8", "rx_frame_err", rx_frame_err, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1, R3: every byte, eight-bit frames
        for (int v = 0; v < 256; v++) begin
            rx0 = n_rx; irq0 = n_irq;
            send(v[7:0], 1'b0, 1'b0, 1'b1);
            check("R1", "count", n_rx - rx0, 1);
            check("R1", "data", last_data, v);
            check("R1", "is_addr", last_addr, 0);
            check("R1", "irq", n_irq - irq0, 0);
            check("R3", "ferr clear", last_ferr, 0);
        end

        // R3: framing error keeps the byte
        for (int v = 0; v < 4; v++) begin
            rx0 = n_rx;
            send(8'hC3 ^ 8'(v), 1'b0, 1'b0, 1'b0);
            check("R3", "count", n_rx - rx0, 1);
            check("R3", "data", last_data, 8'hC3 ^ v);
            check("R3", "ferr", last_ferr, 1);
        end

        // R2: glitch shorter than half a bit
        for (int w = 1; w <= 3; w++) begin
            rx0 = n_rx;
            @(negedge clk) rxd = 1'b0;
            repeat (w) @(negedge clk);
            rxd = 1'b1;
            repeat (3 * BIT) @(negedge clk);
            check("R2", "no byte", n_rx - rx0, 0);
        end

        // R5: receiver off, eight-bit mode
        rx_off = 1'b1;
        rx0 = n_rx;
        send(8'h11, 1'b0, 1'b0, 1'b1);
        check("R5", "dropped 8-bit", n_rx - rx0, 0);
        rx_off = 1'b0;

        // R4, R5: multidrop, manual filter
        mdrop_en = 1'b1;
        for (int v = 0; v < 32; v++) begin
            rx_off = v[0];
            rx0 = n_rx; irq0 = n_irq;
            send(8'(v * 7), 1'b1, 1'b1, 1'b1);
            check("R4", "addr delivered", n_rx - rx0, 1);
            check("R4", "addr data", last_data, (v * 7) & 255);
            check("R4", "is_addr", last_addr, 1);
            check("R4", "irq", n_irq - irq0, 1);
            rx0 = n_rx; irq0 = n_irq;
            send(8'(v + 100), 1'b0, 1'b1, 1'b1);
            check("R5", "data gate", n_rx - rx0, v[0] ? 0 : 1);
            check("R4", "no irq on data", n_irq - irq0, 0);
            if (!v[0]) begin
                check("R5", "data", last_data, v + 100);
                check("R5", "data not addr", last_addr, 0);
            end
        end
        rx_off = 1'b0;

        // R6, R7: auto filter, all addresses, each followed by data
        auto_en = 1'b1;
        for (int a = 0; a < 256; a++) begin
            rx0 = n_rx; irq0 = n_irq;
            send(a[7:0], 1'b1, 1'b1, 1'b1);
            check(a == STATION ? "R6" : "R7", "addr not delivered", n_rx - rx0, 0);
            check(a == STATION ? "R6" : "R7", "irq", n_irq - irq0, a == STATION ? 1 : 0);
            rx0 = n_rx;
            send(~a[7:0], 1'b0, 1'b1, 1'b1);
            check(a == STATION ? "R6" : "R7", "following data", n_rx - rx0, a == STATION ? 1 : 0);
            if (a == STATION) check("R6", "data", last_data, (~a) & 255);
        end
        // R6: reopen directly after a mismatch
        send(8'h00, 1'b1, 1'b1, 1'b1);
        rx0 = n_rx;
        send(STATION, 1'b1, 1'b1, 1'b1);
        send(8'h77, 1'b0, 1'b1, 1'b1);
        check("R6", "reopened", n_rx - rx0, 1);
        check("R6", "reopened data", last_data, 8'h77);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule